// File: doc/BRIEF.md
# Arithmetic Status Flag Generator

This block performs an integer add or subtract on two operands of configurable width and derives six status flags from the outcome: sign, zero, signed overflow, carry/borrow, nibble carry/borrow and even parity of the low byte. The sum and the freshly computed flags are available combinationally in the same cycle as the operands. A six-bit flags register captures the fresh flags on a rising clock edge, but only when the update-enable is high. Instructions that leave the flags alone simply hold the enable low.

Subtraction computes `op_a - op_b - carry_in`, with `carry_in` acting as a borrow-in. It reuses the adder by inverting `op_b` and `carry_in`. The carry and nibble-carry flags are then inverted, so that both report a borrow.

A parameter selects the adder structure. One choice is an explicit ripple chain built by a generate loop. The other is a set of arithmetic expressions that a synthesis tool maps to its own fast carry structure. Both choices give the same ports and the same behaviour.

Top module: `arith_flag_gen`

## Requirements
- R1: `result` equals `(op_a + op_b + carry_in) mod 2^WIDTH` when `sub_sel` is 0, and `(op_a - op_b - carry_in) mod 2^WIDTH` when `sub_sel` is 1.
- R2: The negative flag, bit 4 of `flags_live`, equals the most significant bit of `result`.
- R3: The zero flag, bit 3 of `flags_live`, is 1 exactly when every bit of `result` is 0.
- R4: The overflow flag, bit 5 of `flags_live`, is 1 exactly when the exact signed two's-complement value of the operation lies outside the range of a WIDTH-bit signed number.
- R5: The carry flag, bit 0 of `flags_live`, is the carry out of the top bit when adding. When subtracting, it is 1 exactly when the operation borrows, that is, when `op_a < op_b + carry_in` as unsigned numbers.
- R6: The nibble-carry flag, bit 2 of `flags_live`, is the carry from bit 3 into bit 4 of `op_a[3:0] + op_b[3:0] + carry_in` when adding. When subtracting, it is 1 exactly when `op_a[3:0] < op_b[3:0] + carry_in`.
- R7: The parity flag, bit 1 of `flags_live`, is 1 exactly when `result[7:0]` holds an even number of ones.
- R8: On a rising clock edge with `flag_we` high, `flags_q` takes the value that `flags_live` had just before that edge.
- R9: On a rising clock edge with `flag_we` low, `flags_q` keeps its value, whatever the operands are.
- R10: While `rst_n` is low, `flags_q` is all zeros. This asynchronous clear takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Asynchronous active-low reset of the flags register |
| op_a | input | WIDTH | First operand (minuend when subtracting) |
| op_b | input | WIDTH | Second operand (subtrahend when subtracting) |
| carry_in | input | 1 | Carry-in when adding, borrow-in when subtracting |
| sub_sel | input | 1 | 0 selects add, 1 selects subtract |
| flag_we | input | 1 | Loads the flags register at the next rising edge |
| result | output | WIDTH | Combinational sum or difference |
| flags_live | output | 6 | Combinational flags {V,N,Z,A,P,C}, bit 5 down to bit 0 |
| flags_q | output | 6 | Registered flags, same layout as flags_live |

## Verification
An error in a carry in the adder shows up in `result` and in the carry, nibble-carry and overflow bits of `flags_live` in the same cycle as the operands. The bench therefore compares every live flag against an independent model before each clock edge. A fault in the flags register shows up only after the edge: either the register skips a load it should make, or it takes a load while `flag_we` is low. The bench compares `flags_q` just after every edge, so such a fault is caught within one cycle. Directed operands aim at the points where a bad carry chain or a bad borrow polarity would give itself away: the signed range limits, all-ones plus one, a carry out of the low nibble, and zero minus one.

// File: rtl/asfg_pkg.sv
package asfg_pkg;
   // Number of low result bits covered by the parity flag
   localparam int PARITY_BITS = 8;
   // Bit index whose carry-out drives the nibble flag
   localparam int NIBBLE_MSB  = 3;

   // Adder structure choices
   localparam int ADDER_RIPPLE = 0;
   localparam int ADDER_INFER  = 1;

   typedef struct packed {
      logic ovf;   // bit 5
      logic neg;   // bit 4
      logic zero;  // bit 3
      logic nib;   // bit 2
      logic par;   // bit 1
      logic cy;    // bit 0
   } flags_t;
endpackage

// File: rtl/asfg_adder.sv
module asfg_adder #(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = asfg_pkg::ADDER_RIPPLE
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             cin,
   output logic [WIDTH-1:0] sum,
   output logic             c_nib,
   output logic             c_top_in,
   output logic             c_out
);
   localparam int NIB = asfg_pkg::NIBBLE_MSB + 1;

   if (WIDTH < asfg_pkg::PARITY_BITS) begin : g_bad_width
      $error("asfg_adder: WIDTH must be at least the parity width");
   end

   if (ADDER_KIND == asfg_pkg::ADDER_RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = cin;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]     = a[i] ^ b[i] ^ chain[i];
         assign chain[i+1] = (a[i] & b[i]) | (chain[i] & (a[i] ^ b[i]));
      end
      assign c_nib    = chain[NIB];
      assign c_top_in = chain[WIDTH-1];
      assign c_out    = chain[WIDTH];
   end else if (ADDER_KIND == asfg_pkg::ADDER_INFER) begin : g_infer
      logic [NIB:0]   lo_sum;
      logic [WIDTH-1:0] low_sum;
      logic [WIDTH:0] full_sum;
      assign lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]}
                      + {{NIB{1'b0}}, cin};
      assign low_sum  = {1'b0, a[WIDTH-2:0]} + {1'b0, b[WIDTH-2:0]}
                      + {{(WIDTH-1){1'b0}}, cin};
      assign full_sum = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
      assign sum      = full_sum[WIDTH-1:0];
      assign c_nib    = lo_sum[NIB];
      assign c_top_in = low_sum[WIDTH-1];
      assign c_out    = full_sum[WIDTH];
   end else begin : g_bad_kind
      $error("asfg_adder: unknown ADDER_KIND");
   end
endmodule

// File: rtl/asfg_flag_logic.sv
module asfg_flag_logic #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]      sum,
   input  logic                  c_nib,
   input  logic                  c_top_in,
   input  logic                  c_out,
   input  logic                  is_sub,
   output asfg_pkg::flags_t      flags
);
   localparam int PB = asfg_pkg::PARITY_BITS;

   always_comb begin
      flags      = '0;
      flags.neg  = sum[WIDTH-1];
      flags.zero = (sum == '0);
      flags.ovf  = c_top_in ^ c_out;
      // a borrow is the complement of the adder carry when subtracting
      flags.cy   = c_out ^ is_sub;
      flags.nib  = c_nib ^ is_sub;
      flags.par  = ~(^sum[PB-1:0]);
   end
endmodule

// File: rtl/asfg_flag_reg.sv
module asfg_flag_reg (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  asfg_pkg::flags_t d,
   output asfg_pkg::flags_t q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   // R8: an enabled edge captures the live flags
   assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> q == $past(d));
   // R9: a disabled edge changes nothing
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
   // R10: reset leaves the register cleared
   assert_reset_R10: assert property (@(posedge clk)
      !rst_n |-> q == '0);
endmodule

// File: rtl/arith_flag_gen.sv
module arith_flag_gen #(
   parameter int WIDTH      = 32,
   parameter int ADDER_KIND = asfg_pkg::ADDER_RIPPLE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             carry_in,
   input  logic             sub_sel,
   input  logic             flag_we,
   output logic [WIDTH-1:0] result,
   output logic [5:0]       flags_live,
   output logic [5:0]       flags_q
);
   logic [WIDTH-1:0] b_eff;
   logic             cin_eff;
   logic             c_nib, c_top_in, c_out;
   asfg_pkg::flags_t live, held;

   // subtract as a + ~b + ~borrow
   assign b_eff   = sub_sel ? ~op_b : op_b;
   assign cin_eff = carry_in ^ sub_sel;

   asfg_adder #(.WIDTH(WIDTH), .ADDER_KIND(ADDER_KIND)) u_adder (
      .a(op_a), .b(b_eff), .cin(cin_eff), .sum(result),
      .c_nib(c_nib), .c_top_in(c_top_in), .c_out(c_out)
   );

   asfg_flag_logic #(.WIDTH(WIDTH)) u_flags (
      .sum(result), .c_nib(c_nib), .c_top_in(c_top_in), .c_out(c_out),
      .is_sub(sub_sel), .flags(live)
   );

   asfg_flag_reg u_freg (
      .clk(clk), .rst_n(rst_n), .we(flag_we), .d(live), .q(held)
   );

   assign flags_live = live;
   assign flags_q    = held;

   // R4: same-sign add (or opposite-sign subtract) with no carry/borrow
   // in flips sign exactly when overflowing
   assert_ovf_add_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_sel && !carry_in) |->
         live.ovf == ((op_a[WIDTH-1] == op_b[WIDTH-1]) &&
                      (result[WIDTH-1] != op_a[WIDTH-1])));
   assert_ovf_sub_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_sel && !carry_in) |->
         live.ovf == ((op_a[WIDTH-1] != op_b[WIDTH-1]) &&
                      (result[WIDTH-1] != op_a[WIDTH-1])));
   // R5: unsigned wrap on add, unsigned less-than on subtract
   assert_carry_add_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_sel && !carry_in) |-> live.cy == (result < op_a));
   assert_borrow_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_sel && !carry_in) |-> live.cy == (op_a < op_b));
   // R3 and R2: a zero result cannot be negative
   assert_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      live.zero |-> (!live.neg && result == '0));
   // R7: parity by population count
   assert_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
      live.par == ($countones(result[asfg_pkg::PARITY_BITS-1:0]) % 2 == 0));
   // R1: subtract with no borrow-in undoes the add
   assert_sub_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sub_sel && !carry_in) |-> (result + op_b) == op_a);
endmodule

// File: tb/arith_flag_gen_bench.sv
`timescale 1ns/1ps
module arith_flag_gen_bench;
   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0;
   logic         carry_in = 1'b0, sub_sel = 1'b0, flag_we = 1'b0;
   logic [W-1:0] result;
   logic [5:0]   flags_live, flags_q;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   logic [5:0] model_q = '0;

   always #2 clk = ~clk;

   arith_flag_gen #(.WIDTH(W)) u_arith_flag_gen (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
      .carry_in(carry_in), .sub_sel(sub_sel), .flag_we(flag_we),
      .result(result), .flags_live(flags_live), .flags_q(flags_q)
   );

   task automatic check(input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ref_result(input logic [W-1:0] a, b,
                                               input logic c, s);
      return s ? (a - b - W'(c)) : (a + b + W'(c));
   endfunction

   // flags layout {V,N,Z,A,P,C}
   function automatic logic [5:0] ref_flags(input logic [W-1:0] a, b,
                                            input logic c, s);
      logic [W-1:0] r;
      logic [W:0]   wide;
      logic [4:0]   nib;
      longint       sa, sb, exact;
      logic v, n, z, ax, p, cy;
      r    = ref_result(a, b, c, s);
      sa   = longint'($signed(a));
      sb   = longint'($signed(b));
      if (s) begin
         wide  = {1'b0, a} - {1'b0, b} - (W+1)'(c);
         nib   = {1'b0, a[3:0]} - {1'b0, b[3:0]} - 5'(c);
         exact = sa - sb - longint'(c);
      end else begin
         wide  = {1'b0, a} + {1'b0, b} + (W+1)'(c);
         nib   = {1'b0, a[3:0]} + {1'b0, b[3:0]} + 5'(c);
         exact = sa + sb + longint'(c);
      end
      cy = wide[W];
      ax = nib[4];
      v  = (exact > 64'sd2147483647) || (exact < -64'sd2147483648);
      n  = r[W-1];
      z  = (r == '0);
      p  = ($countones(r[7:0]) % 2) == 0;
      return {v, n, z, ax, p, cy};
   endfunction

   task automatic apply(input logic [W-1:0] a, b, input logic c, s, we);
      logic [5:0] ef;
      @(negedge clk);
      op_a = a; op_b = b; carry_in = c; sub_sel = s; flag_we = we;
      #1;
      ef = ref_flags(a, b, c, s);
      check("R1 result", 64'(result), 64'(ref_result(a, b, c, s)));
      check("R2 negative", 64'(flags_live[4]), 64'(ef[4]));
      check("R3 zero", 64'(flags_live[3]), 64'(ef[3]));
      check("R4 overflow", 64'(flags_live[5]), 64'(ef[5]));
      check("R5 carry/borrow", 64'(flags_live[0]), 64'(ef[0]));
      check("R6 nibble carry", 64'(flags_live[2]), 64'(ef[2]));
      check("R7 parity", 64'(flags_live[1]), 64'(ef[1]));
      if (we) model_q = ef;
      @(posedge clk);
      #1;
      if (we) check("R8 register load", 64'(flags_q), 64'(model_q));
      else    check("R9 register hold", 64'(flags_q), 64'(model_q));
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      // reset with an active write pending
      op_a = 32'h8000_0000; op_b = 32'h8000_0000; flag_we = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R10 reset clears", 64'(flags_q), 64'h0);
      @(negedge clk);
      rst_n = 1'b1;
      flag_we = 1'b0;

      // directed corners
      apply(32'h0000_0000, 32'h0000_0000, 1'b0, 1'b0, 1'b1); // Z, P
      apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b1); // V, N, A
      apply(32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 1'b0, 1'b1); // C, Z, A
      apply(32'h0000_000F, 32'h0000_0001, 1'b0, 1'b0, 1'b0); // A, hold
      apply(32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 1'b1); // V, C, Z
      apply(32'h7FFF_FFFF, 32'h0000_0000, 1'b1, 1'b0, 1'b1); // V via cin
      apply(32'h0000_0000, 32'h0000_0001, 1'b0, 1'b1, 1'b1); // borrow
      apply(32'h0000_0010, 32'h0000_0001, 1'b0, 1'b1, 1'b1); // nib borrow
      apply(32'h8000_0000, 32'h0000_0001, 1'b0, 1'b1, 1'b1); // sub V
      apply(32'h0000_0000, 32'h8000_0000, 1'b0, 1'b1, 1'b1); // sub V
      apply(32'h0000_0000, 32'h8000_0000, 1'b1, 1'b1, 1'b0); // no V, hold
      apply(32'h0000_0005, 32'h0000_0005, 1'b1, 1'b1, 1'b1); // borrow-in
      apply(32'h0000_0005, 32'h0000_0005, 1'b0, 1'b1, 1'b1); // exact zero

      // constrained random: bias toward small and edge values
      for (int i = 0; i < 400; i++) begin
         logic [W-1:0] a, b;
         int sel;
         sel = int'($urandom_range(0, 3));
         a = $urandom();
         b = $urandom();
         if (sel == 1) begin a = a & 32'h0000_00FF; b = b & 32'h0000_00FF; end
         if (sel == 2) begin a = a | 32'h7FFF_FF00; b = b & 32'h0000_000F; end
         apply(a, b, 1'($urandom()), 1'($urandom()), 1'($urandom()));
      end

      // asynchronous reset mid-run
      @(negedge clk);
      flag_we = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R10 async clear", 64'(flags_q), 64'h0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures",
               checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures",
                  checks, fails);
         $finish;
      end
   end
endmodule